// File: doc/BRIEF.md
# Call/Return Stack Engine

This block runs the stack side of a small processor: it moves register values, return addresses and saved flags between the core and a byte-wide data memory, one byte per cycle, under a 16-bit stack pointer that it owns. The core hands it one command at a time. A command carries an operation code, a register value, an immediate target and the address of the current instruction. The engine walks through the memory accesses that command needs and then reports the result with a one-cycle done strobe.

The stack grows toward higher addresses. A push writes at the pointer and then advances it. A pop steps the pointer back and then reads. Word values are laid out high byte first, at the lower address. A call saves the address of the instruction after the call and redirects the program counter. A return restores the program counter. A return from interrupt restores a flags word and then the program counter. Instruction decode and interrupt handling sit outside this block.

Top module: `stack_engine`

## Requirements
- R1: While reset is high and in the cycle after it falls, the stack pointer equals the SP_RESET parameter (default 0). done, busy, all three load strobes, mem_we and mem_re are all low.
- R2: Code 0x55 (push word) writes cmd_reg[15:8] at address SP, then cmd_reg[7:0] at SP+1, and leaves SP increased by 2.
- R3: Code 0x5D (pop word) reads SP-1 into reg_out[7:0], then SP-2 into reg_out[15:8], and leaves SP decreased by 2.
- R4: Code 0x61 (push byte) writes cmd_reg[7:0] at SP and leaves SP increased by 1.
- R5: Code 0x65 (pop byte) reads SP-1 into reg_out[7:0] and leaves SP decreased by 1. reg_out[15:8] takes cmd_reg[15:8], so the high byte of the destination is unchanged.
- R6: Codes 0x51 (call through register) and 0x5E (call immediate) push a return address as a word, high byte first. The return address is cur_pc+2 for 0x51 and cur_pc+3 for 0x5E. pc_out then becomes cmd_reg for 0x51 or cmd_imm for 0x5E.
- R7: Code 0x50 (return) pops a word, low byte from SP-1 and high byte from SP-2, into pc_out. SP decreases by 2.
- R8: Code 0x54 (return from interrupt) first pops a word into flags_out, then pops a second word into pc_out. SP decreases by 4.
- R9: A command is accepted on a clock edge where cmd_valid is high and busy is low. It then makes exactly one memory access per cycle, for N cycles, where N is the command's byte count. done is high for exactly one cycle, N+1 cycles after the accepting edge.
- R10: While busy is high, cmd_valid and every command input are ignored. The engine uses the values it captured when it accepted the command.
- R11: A code outside the eight above is ignored: no memory access, no done, and SP unchanged.
- R12: Stack pointer arithmetic and every access address wrap modulo 2^16.
- R13: Each load strobe pulses only together with done. pc_load pulses for call, return and return from interrupt. flags_load pulses only for return from interrupt. reg_load pulses only for the two pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 8 | Operation code |
| cmd_reg | input | 16 | Register value: push source, pop destination's current value, or call target |
| cmd_imm | input | 16 | Immediate call target |
| cur_pc | input | 16 | Address of the call instruction |
| busy | output | 1 | Command in progress |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid in the same cycle as the address |
| done | output | 1 | One-cycle completion strobe |
| pc_load | output | 1 | pc_out updated |
| pc_out | output | 16 | New program counter |
| flags_load | output | 1 | flags_out updated |
| flags_out | output | 16 | Restored flags |
| reg_load | output | 1 | reg_out updated |
| reg_out | output | 16 | Popped register value |
| sp_out | output | 16 | Current stack pointer |

## Verification
Two cases are hard to reach from the ports.

The first is the pointer wrapping around address zero. The pointer resets to zero, so the directed stimulus opens with a byte pop straight after reset. That pop reads address 0xFFFF. A word push follows at once, and its two bytes straddle 0xFFFF and 0x0000.

The second is a command arriving while another is in flight. The bench holds cmd_valid high with a different opcode and an altered register value for the whole of a command, then checks that exactly one result appears. It also checks that the result matches the captured inputs.

Long random mixes of all eight operations drive the pointer back and forth across zero. A byte-level model in the bench predicts every popped value, every written byte and the final pointer.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int BYTE_W       = 8;
    localparam int WORD_W       = 2 * BYTE_W;
    localparam int ADDR_W       = WORD_W;
    localparam int MAX_STEPS    = 4;
    localparam int IDX_W        = $clog2(MAX_STEPS);
    localparam int GATHER_W     = MAX_STEPS * BYTE_W;
    localparam int CALL_REG_LEN = 2;
    localparam int CALL_IMM_LEN = 3;

    typedef enum logic [7:0] {
        OP_RET   = 8'h50,
        OP_CALLR = 8'h51,
        OP_RETI  = 8'h54,
        OP_PUSHW = 8'h55,
        OP_POPW  = 8'h5D,
        OP_CALLI = 8'h5E,
        OP_PUSHB = 8'h61,
        OP_POPB  = 8'h65
    } op_e;

    // one memory access of a command
    typedef struct packed {
        logic wr;
        logic rd;
        logic hi;    // write selects the high byte of the staged word
        logic last;
    } step_t;

    // operands captured at acceptance
    typedef struct packed {
        logic [WORD_W-1:0] wword;
        logic [WORD_W-1:0] keep;
        logic [ADDR_W-1:0] target;
    } cmd_t;

    function automatic logic is_legal(input logic [7:0] code);
        case (code)
            8'h50, 8'h51, 8'h54, 8'h55,
            8'h5D, 8'h5E, 8'h61, 8'h65: is_legal = 1'b1;
            default:                    is_legal = 1'b0;
        endcase
    endfunction

    function automatic step_t plan_step(input op_e op, input logic [IDX_W-1:0] idx);
        step_t s;
        s = '0;
        case (op)
            OP_PUSHW, OP_CALLR, OP_CALLI: begin
                s.wr   = 1'b1;
                s.hi   = (idx == IDX_W'(0));
                s.last = (idx == IDX_W'(1));
            end
            OP_PUSHB: begin
                s.wr   = 1'b1;
                s.last = 1'b1;
            end
            OP_POPW, OP_RET: begin
                s.rd   = 1'b1;
                s.last = (idx == IDX_W'(1));
            end
            OP_POPB: begin
                s.rd   = 1'b1;
                s.last = 1'b1;
            end
            OP_RETI: begin
                s.rd   = 1'b1;
                s.last = (idx == IDX_W'(MAX_STEPS - 1));
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr
    import stk_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              dec,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] below
);

    assign below = sp - ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst)      sp <= RST_VAL;
        else if (inc) sp <= sp + ADDR_W'(1);
        else if (dec) sp <= below;
    end

    AST_PTR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(inc && dec)); // R9

endmodule

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    output logic             busy,
    output logic             start,
    output op_e              op,
    output logic [IDX_W-1:0] idx,
    output step_t            step
);

    typedef enum logic { S_IDLE, S_RUN } st_e;
    st_e st;

    assign busy  = (st == S_RUN);
    assign start = cmd_valid && !busy && is_legal(cmd_op);
    assign step  = busy ? plan_step(op, idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            op  <= OP_PUSHW;
            idx <= '0;
        end else if (start) begin
            st  <= S_RUN;
            op  <= op_e'(cmd_op);
            idx <= '0;
        end else if (busy) begin
            if (step.last) begin
                st  <= S_IDLE;
                idx <= '0;
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R10

endmodule

// File: rtl/stk_gather.sv
module stk_gather
    import stk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic [IDX_W-1:0]    idx,
    input  logic [BYTE_W-1:0]   rdata,
    output logic [GATHER_W-1:0] merged
);

    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_lane
        logic [BYTE_W-1:0] hold_q;
        logic              hit;

        assign hit = capture && (idx == IDX_W'(g));
        assign merged[g*BYTE_W +: BYTE_W] = hit ? rdata : hold_q;

        always_ff @(posedge clk) begin
            if (rst)      hold_q <= '0;
            else if (hit) hold_q <= rdata;
        end
    end

endmodule

// File: rtl/stack_engine.sv
module stack_engine
    import stk_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_reg,
    input  logic [WORD_W-1:0] cmd_imm,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              done,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_out,
    output logic              flags_load,
    output logic [WORD_W-1:0] flags_out,
    output logic              reg_load,
    output logic [WORD_W-1:0] reg_out,
    output logic [ADDR_W-1:0] sp_out
);

    logic              start;
    op_e               op;
    logic [IDX_W-1:0]  idx;
    step_t             step;
    logic [ADDR_W-1:0] sp_below;
    logic [GATHER_W-1:0] merged;
    cmd_t              lat;
    logic              is_call, is_calli;

    stk_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .busy      (busy),
        .start     (start),
        .op        (op),
        .idx       (idx),
        .step      (step)
    );

    stk_ptr #(.RST_VAL(SP_RESET)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .inc   (step.wr),
        .dec   (step.rd),
        .sp    (sp_out),
        .below (sp_below)
    );

    stk_gather u_gather (
        .clk     (clk),
        .rst     (rst),
        .capture (step.rd),
        .idx     (idx),
        .rdata   (mem_rdata),
        .merged  (merged)
    );

    // capture operands when a command is taken
    assign is_calli = (cmd_op == 8'(OP_CALLI));
    assign is_call  = is_calli || (cmd_op == 8'(OP_CALLR));

    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
        end else if (start) begin
            lat.keep   <= cmd_reg;
            lat.wword  <= is_call
                        ? cur_pc + (is_calli ? ADDR_W'(CALL_IMM_LEN) : ADDR_W'(CALL_REG_LEN))
                        : cmd_reg;
            lat.target <= is_calli ? cmd_imm : cmd_reg;
        end
    end

    // memory port: push at SP, pop at SP-1
    assign mem_we    = step.wr;
    assign mem_re    = step.rd;
    assign mem_addr  = step.wr ? sp_out : sp_below;
    assign mem_wdata = step.hi ? lat.wword[WORD_W-1:BYTE_W] : lat.wword[BYTE_W-1:0];

    // results, registered on the last access
    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            pc_load    <= 1'b0;
            flags_load <= 1'b0;
            reg_load   <= 1'b0;
            pc_out     <= '0;
            flags_out  <= '0;
            reg_out    <= '0;
        end else begin
            done       <= step.last;
            pc_load    <= 1'b0;
            flags_load <= 1'b0;
            reg_load   <= 1'b0;
            if (step.last) begin
                case (op)
                    OP_POPW: begin
                        reg_out  <= merged[WORD_W-1:0];
                        reg_load <= 1'b1;
                    end
                    OP_POPB: begin
                        reg_out  <= {lat.keep[WORD_W-1:BYTE_W], merged[BYTE_W-1:0]};
                        reg_load <= 1'b1;
                    end
                    OP_RET: begin
                        pc_out  <= merged[WORD_W-1:0];
                        pc_load <= 1'b1;
                    end
                    OP_RETI: begin
                        flags_out  <= merged[WORD_W-1:0];
                        pc_out     <= merged[2*WORD_W-1:WORD_W];
                        flags_load <= 1'b1;
                        pc_load    <= 1'b1;
                    end
                    OP_CALLR, OP_CALLI: begin
                        pc_out  <= lat.target;
                        pc_load <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !mem_re)); // R11

    AST_EXCL_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R9

    AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_out == $past(sp_out) + ADDR_W'(1))); // R2

    AST_RD_RETREAT: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> (sp_out == $past(sp_out) - ADDR_W'(1))); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_LOAD_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (pc_load || flags_load || reg_load) |-> done); // R13

endmodule

// File: tb/tb_stack_engine.sv
module tb_stack_engine;
    import stk_pkg::*;

    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 150000;
    localparam int N_RANDOM     = 400;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [7:0]  cmd_op;
    logic [15:0] cmd_reg, cmd_imm, cur_pc;
    logic        busy, mem_we, mem_re, done, pc_load, flags_load, reg_load;
    logic [15:0] mem_addr, pc_out, flags_out, reg_out, sp_out;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  ram [0:65535];
    logic [7:0]  mdl [0:65535];
    logic [15:0] m_sp;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_engine dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_imm(cmd_imm), .cur_pc(cur_pc), .busy(busy),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
        .pc_load(pc_load), .pc_out(pc_out), .flags_load(flags_load),
        .flags_out(flags_out), .reg_load(reg_load), .reg_out(reg_out),
        .sp_out(sp_out)
    );

    assign mem_rdata = ram[mem_addr];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [15:0] rv,
                           input logic [15:0] imm, input logic [15:0] pc, input bit hold);
        int len = 0;
        int nw = 0;
        int cyc = 0;
        logic [15:0] wa0 = '0, wa1 = '0, ret;
        logic [15:0] e_pc = pc_out, e_fl = flags_out, e_reg = reg_out;
        bit e_pcl = 0, e_fll = 0, e_rgl = 0;
        string tag;
        case (op)
            8'h55: begin
                tag = "R2 push word"; len = 2; nw = 2;
                wa0 = m_sp; wa1 = m_sp + 16'd1;
                mdl[wa0] = rv[15:8]; mdl[wa1] = rv[7:0]; m_sp = m_sp + 16'd2;
            end
            8'h5D: begin
                tag = "R3 pop word"; len = 2; e_rgl = 1;
                e_reg = {mdl[m_sp - 16'd2], mdl[m_sp - 16'd1]}; m_sp = m_sp - 16'd2;
            end
            8'h61: begin
                tag = "R4 push byte"; len = 1; nw = 1;
                wa0 = m_sp; mdl[wa0] = rv[7:0]; m_sp = m_sp + 16'd1;
            end
            8'h65: begin
                tag = "R5 pop byte"; len = 1; e_rgl = 1;
                e_reg = {rv[15:8], mdl[m_sp - 16'd1]}; m_sp = m_sp - 16'd1;
            end
            8'h51, 8'h5E: begin
                tag = "R6 call"; len = 2; nw = 2; e_pcl = 1;
                ret = pc + ((op == 8'h51) ? 16'd2 : 16'd3);
                e_pc = (op == 8'h51) ? rv : imm;
                wa0 = m_sp; wa1 = m_sp + 16'd1;
                mdl[wa0] = ret[15:8]; mdl[wa1] = ret[7:0]; m_sp = m_sp + 16'd2;
            end
            8'h50: begin
                tag = "R7 return"; len = 2; e_pcl = 1;
                e_pc = {mdl[m_sp - 16'd2], mdl[m_sp - 16'd1]}; m_sp = m_sp - 16'd2;
            end
            default: begin
                tag = "R8 return from interrupt"; len = 4; e_pcl = 1; e_fll = 1;
                e_fl = {mdl[m_sp - 16'd2], mdl[m_sp - 16'd1]};
                e_pc = {mdl[m_sp - 16'd4], mdl[m_sp - 16'd3]};
                m_sp = m_sp - 16'd4;
            end
        endcase

        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_reg = rv; cmd_imm = imm; cur_pc = pc;
        @(posedge clk);
        forever begin
            @(negedge clk);
            cyc++;
            if (done || cyc > 20) begin
                cmd_valid = 1'b0;
                break;
            end
            if (hold) begin
                cmd_op = (op == 8'h65) ? 8'h61 : 8'h65;
                cmd_reg = ~rv; cmd_imm = ~imm; cur_pc = ~pc;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        check({"R9 latency ", tag}, cyc, len + 1);
        check({tag, " sp"}, {16'd0, sp_out}, {16'd0, m_sp});
        check({"R13 pc_load ", tag}, {31'd0, pc_load}, {31'd0, e_pcl});
        check({"R13 flags_load ", tag}, {31'd0, flags_load}, {31'd0, e_fll});
        check({"R13 reg_load ", tag}, {31'd0, reg_load}, {31'd0, e_rgl});
        if (e_pcl) check({tag, " pc_out"}, {16'd0, pc_out}, {16'd0, e_pc});
        if (e_fll) check({tag, " flags_out"}, {16'd0, flags_out}, {16'd0, e_fl});
        if (e_rgl) check({tag, " reg_out"}, {16'd0, reg_out}, {16'd0, e_reg});
        if (nw >= 1) check({tag, " first byte"}, {24'd0, ram[wa0]}, {24'd0, mdl[wa0]});
        if (nw >= 2) check({tag, " second byte"}, {24'd0, ram[wa1]}, {24'd0, mdl[wa1]});
        if (hold) begin
            int extra = 0;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (done) extra++;
            end
            check("R10 no extra command while busy", extra, 0);
            check("R10 sp after held valid", {16'd0, sp_out}, {16'd0, m_sp});
        end
    endtask

    task automatic run_illegal(input logic [7:0] op);
        int seen = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (done || mem_we || mem_re || busy) seen++;
            @(negedge clk);
        end
        check("R11 illegal code activity", seen, 0);
        check("R11 illegal code sp", {16'd0, sp_out}, {16'd0, m_sp});
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [7:0] ops [0:7];
        ops[0] = 8'h55; ops[1] = 8'h5D; ops[2] = 8'h61; ops[3] = 8'h65;
        ops[4] = 8'h51; ops[5] = 8'h5E; ops[6] = 8'h50; ops[7] = 8'h54;
        void'($urandom(32'd2024));
        for (int i = 0; i < 65536; i++) begin
            ram[i] = 8'(i) ^ 8'(i >> 8) ^ 8'h5A;
            mdl[i] = ram[i];
        end
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0;
        cmd_reg = '0; cmd_imm = '0; cur_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset sp", {16'd0, sp_out}, 32'd0);
        check("R1 reset busy/done", {30'd0, busy, done}, 32'd0);
        check("R1 reset memory strobes", {30'd0, mem_we, mem_re}, 32'd0);
        check("R1 reset loads", {29'd0, pc_load, flags_load, reg_load}, 32'd0);
        rst = 1'b0;
        m_sp = 16'h0000;
        @(negedge clk);
        check("R1 idle after reset", {29'd0, busy, done, mem_we}, 32'd0);

        // R12: wrap below zero, then a word straddling 0xFFFF/0x0000
        run_cmd(8'h65, 16'hC3C3, 16'h0, 16'h0, 0);
        check("R12 sp wrapped", {16'd0, sp_out}, 32'h0000FFFF);
        run_cmd(8'h55, 16'hBEEF, 16'h0, 16'h0, 0);
        check("R12 high byte at 0xFFFF", {24'd0, ram[16'hFFFF]}, 32'hBE);
        check("R12 low byte at 0x0000", {24'd0, ram[16'h0000]}, 32'hEF);
        run_cmd(8'h5D, 16'h0000, 16'h0, 16'h0, 0);
        check("R12 word back across zero", {16'd0, reg_out}, 32'h0000BEEF);

        run_cmd(8'h55, 16'hA1B2, 16'h0, 16'h0, 0);
        run_cmd(8'h5D, 16'h0000, 16'h0, 16'h0, 0);
        check("R3 round trip", {16'd0, reg_out}, 32'h0000A1B2);
        run_cmd(8'h61, 16'h1234, 16'h0, 16'h0, 0);
        run_cmd(8'h65, 16'h9900, 16'h0, 16'h0, 0);
        check("R5 high byte kept", {16'd0, reg_out}, 32'h00009934);
        run_cmd(8'h51, 16'h4000, 16'h0, 16'h0200, 0);
        run_cmd(8'h50, 16'h0, 16'h0, 16'h0, 0);
        check("R7 return to call+2", {16'd0, pc_out}, 32'h00000202);
        run_cmd(8'h5E, 16'h0, 16'h5000, 16'h12FF, 0);
        run_cmd(8'h50, 16'h0, 16'h0, 16'h0, 0);
        check("R7 return to call+3", {16'd0, pc_out}, 32'h00001302);
        run_cmd(8'h5E, 16'h0, 16'h6000, 16'h0300, 0);
        run_cmd(8'h55, 16'h00C5, 16'h0, 16'h0, 0);
        run_cmd(8'h54, 16'h0, 16'h0, 16'h0, 0);
        check("R8 flags restored", {16'd0, flags_out}, 32'h000000C5);
        check("R8 pc restored", {16'd0, pc_out}, 32'h00000303);

        run_cmd(8'h55, 16'h7788, 16'h0, 16'h0, 1);
        run_cmd(8'h65, 16'hAB00, 16'h0, 16'h0, 1);
        run_illegal(8'h00);
        run_illegal(8'h56);

        for (int n = 0; n < N_RANDOM; n++) begin
            run_cmd(ops[$urandom % 8], 16'($urandom), 16'($urandom),
                    16'($urandom), ($urandom % 8) == 0);
        end
        finish_run();
    end

endmodule